// File: doc/BRIEF.md
# Shared-Pipeline ADC Conversion Scheduler

This block is the digital sequencer in front of a pipelined analog-to-digital core that four virtual channels share. It collects conversion requests from three sources: a software start strobe per channel, a bus of eight event lines, and a free-running mode. On each tick of the converter clock it issues at most one channel start. It models the core's pipeline as a delay line, so that it knows when each conversion finishes, and it then reports a one-cycle done pulse that carries the channel index. It also generates the converter clock enable by dividing the peripheral clock by a programmable power of two.

Event lines are read through a window, which is a group of consecutive lines chosen by a 3-bit code. The event mode decides how the window is used. In per-channel mode each line of the window triggers its own channel. In sweep mode the lowest line of the window starts one pass over the chosen channel set. Synchronized-sweep mode does the same, but it first aborts the conversions in flight and realigns the converter clock to the event. Conversion length depends on the resolution and on a per-channel gain bit. Because of this, two conversions started on consecutive ticks can finish on the same tick. The block then reports both, one clock apart.

Top module: `adc_vch_sched`

## Requirements
- R1: `adc_tick` is a single-clock pulse that repeats every 4 << `cfg_div` peripheral clocks (`cfg_div` 0..7 gives a division by 4..512).
- R2: A request from `sw_start` or from a per-channel event sets one pending bit for its channel. Further requests for that channel before its start is issued merge into the same bit and give only one start.
- R3: `start_valid` pulses for one clock, in the clock after an `adc_tick`, only when a request is pending. `start_ch` then names the lowest-numbered pending channel.
- R4: A channel started at tick T completes at tick T+L. L is 7 when `cfg_res8`=0 and 5 when `cfg_res8`=1, plus 1 when `cfg_gain[ch]`=1. Its `done` pulse appears in the clock after tick T+L.
- R5: `done` lasts one clock and carries `done_ch`. When two channels complete on the same tick, the lower-numbered one is reported first and the other follows in the next clock.
- R6: `cfg_win` selects the event window. Codes 0..4 select four lines starting at line `cfg_win`. Code 5 selects lines 4..6, code 6 selects lines 6..7 and code 7 selects line 7 only. Lines outside the window have no effect.
- R7: When `cfg_evmode` is 1..4, window line k triggers channel k for every k < `cfg_evmode`. Codes 0 and 7 disable event triggering.
- R8: When `cfg_evmode`=5, a pulse on the lowest window line requests every channel in the sweep set. `cfg_sweep`=n selects channels 0..n.
- R9: When `cfg_evmode`=6, a pulse on the lowest window line aborts all conversions in flight, so that they give no `done`. It replaces the pending set with the sweep set and restarts the divider, so that the next `adc_tick` comes 4 << `cfg_div` clocks later.
- R10: When `cfg_free`=1 and nothing is pending at a tick, the sweep set is reloaded and its lowest channel is started on that tick. The channels of the set are then converted back to back.
- R11: While `rst` is high, and in the clock after it, `adc_tick`, `start_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 3 | Divider code, giving a division by 4 << code |
| cfg_res8 | input | 1 | 1 selects the short (8-bit) conversion latency |
| cfg_gain | input | 4 | Per-channel gain bit, each adding one cycle of latency |
| cfg_free | input | 1 | Free-running enable |
| cfg_sweep | input | 2 | Sweep set: channels 0..n |
| cfg_win | input | 3 | Event window code |
| cfg_evmode | input | 3 | 0 none, 1..4 per-channel, 5 sweep, 6 synchronized sweep |
| sw_start | input | 4 | Per-channel software start strobes |
| evt_in | input | 8 | Event line pulses |
| adc_tick | output | 1 | Converter clock enable |
| start_valid | output | 1 | A channel start was issued |
| start_ch | output | 2 | Channel that was started |
| done | output | 1 | A conversion completed |
| done_ch | output | 2 | Channel whose conversion completed |

## Verification
The hardest case to reach from the ports is two conversions completing on the same tick. This only happens when a channel with gain is started one tick before a channel without gain. The stimulus therefore sets gain on channel 0 alone and strobes channels 0 and 1 together. A synchronized-sweep abort is also hard to observe, because it must land while conversions are still in the delay line. The bench fires the aligning event a few ticks after a four-channel start and confirms that the aborted channels never report done. A behavioural model with a queue of in-flight conversions, each with its own remaining tick count, is compared with the ports on every clock.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
  localparam int NCH     = 4;
  localparam int NEVT    = 8;
  localparam int LAT_HI  = 7;
  localparam int LAT_LO  = 5;
  localparam int DEPTH   = LAT_HI + 1;
  localparam int CH_W    = $clog2(NCH);

  typedef enum logic [2:0] {
    EVM_NONE  = 3'd0,
    EVM_SWEEP = 3'd5,
    EVM_SYNC  = 3'd6,
    EVM_OFF7  = 3'd7
  } evmode_e;

  function automatic logic [NCH-1:0] lowest_bit(input logic [NCH-1:0] m);
    return m & (~m + NCH'(1));
  endfunction

  function automatic logic [CH_W-1:0] bit_index(input logic [NCH-1:0] oh);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = 0; i < NCH; i++)
      if (oh[i]) r = CH_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/adc_sched_clkdiv.sv
module adc_sched_clkdiv #(
  parameter int CODE_W = 3,
  parameter int SHIFT0 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CNT_W = SHIFT0 + (1 << CODE_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = (CNT_W'(1) << (SHIFT0 + int'(code))) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_sched_trig.sv
module adc_sched_trig
  import adc_sched_pkg::*;
(
  input  logic [2:0]      win,
  input  logic [2:0]      evmode,
  input  logic [1:0]      sweep,
  input  logic [NEVT-1:0] evt_in,
  output logic [NCH-1:0]  chan_req,
  output logic [NCH-1:0]  sweep_mask,
  output logic            sweep_hit,
  output logic            sync_hit
);
  logic [2:0]      base;
  logic [2:0]      width;
  logic [NEVT-1:0] shifted;

  always_comb begin
    case (win)
      3'd5:    begin base = 3'd4; width = 3'd3; end
      3'd6:    begin base = 3'd6; width = 3'd2; end
      3'd7:    begin base = 3'd7; width = 3'd1; end
      default: begin base = win;  width = 3'd4; end
    endcase
  end

  assign shifted = evt_in >> base;

  genvar k;
  generate
    for (k = 0; k < NCH; k++) begin : g_ch
      assign chan_req[k] = shifted[k] && (3'(k) < width) &&
                           (evmode >= 3'd1) && (evmode <= 3'd4) &&
                           (3'(k) < evmode);
      assign sweep_mask[k] = (k <= int'(sweep));
    end
  endgenerate

  assign sweep_hit = shifted[0] && (evmode == EVM_SWEEP);
  assign sync_hit  = shifted[0] && (evmode == EVM_SYNC);
endmodule

// File: rtl/adc_sched_delay.sv
module adc_sched_delay #(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             advance,
  input  logic             ins_valid,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [NCH-1:0]   ins_mask,
  output logic [NCH-1:0]   head
);
  logic [NCH-1:0] line_q [DEPTH];

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stage
      logic [NCH-1:0] from_up;
      if (i == DEPTH - 1) begin : g_top
        assign from_up = '0;
      end else begin : g_mid
        assign from_up = line_q[i+1];
      end
      always_ff @(posedge clk) begin
        if (rst || flush)
          line_q[i] <= '0;
        else if (advance)
          line_q[i] <= from_up |
                       ((ins_valid && (ins_idx == IDX_W'(i))) ? ins_mask : '0);
      end
    end
  endgenerate

  assign head = line_q[0];
endmodule

// File: rtl/adc_vch_sched.sv
module adc_vch_sched
  import adc_sched_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      cfg_div,
  input  logic            cfg_res8,
  input  logic [3:0]      cfg_gain,
  input  logic            cfg_free,
  input  logic [1:0]      cfg_sweep,
  input  logic [2:0]      cfg_win,
  input  logic [2:0]      cfg_evmode,
  input  logic [3:0]      sw_start,
  input  logic [7:0]      evt_in,
  output logic            adc_tick,
  output logic            start_valid,
  output logic [1:0]      start_ch,
  output logic            done,
  output logic [1:0]      done_ch
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [NCH-1:0] chan_req, sweep_mask, pend_q, eff, pick, head, expire;
  logic [NCH-1:0] left_q;
  logic           sweep_hit, sync_hit, tick_eff, start_now;
  logic [IDX_W-1:0] ins_idx;

  adc_sched_clkdiv #(.CODE_W(3), .SHIFT0(2)) u_div (
    .clk(clk), .rst(rst), .restart(sync_hit), .code(cfg_div), .tick(adc_tick)
  );

  adc_sched_trig u_trig (
    .win(cfg_win), .evmode(cfg_evmode), .sweep(cfg_sweep), .evt_in(evt_in),
    .chan_req(chan_req), .sweep_mask(sweep_mask),
    .sweep_hit(sweep_hit), .sync_hit(sync_hit)
  );

  always_comb begin
    tick_eff  = adc_tick && !sync_hit;
    eff       = pend_q | ((cfg_free && pend_q == '0) ? sweep_mask : '0);
    pick      = lowest_bit(eff);
    start_now = tick_eff && (eff != '0);
    ins_idx   = IDX_W'((cfg_res8 ? LAT_LO : LAT_HI) - 1) +
                IDX_W'(cfg_gain[bit_index(pick)]);
    expire    = tick_eff ? head : '0;
  end

  adc_sched_delay #(.NCH(NCH), .DEPTH(DEPTH)) u_line (
    .clk(clk), .rst(rst), .flush(sync_hit), .advance(tick_eff),
    .ins_valid(start_now), .ins_idx(ins_idx), .ins_mask(pick), .head(head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else if (sync_hit) begin
      pend_q <= sweep_mask | sw_start;
    end else begin
      pend_q <= (tick_eff ? (eff & ~pick) : pend_q) | sw_start | chan_req |
                (sweep_hit ? sweep_mask : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_valid <= 1'b0;
      start_ch    <= '0;
    end else begin
      start_valid <= start_now;
      if (start_now) start_ch <= bit_index(pick);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sync_hit) begin
      done    <= 1'b0;
      done_ch <= '0;
      left_q  <= '0;
    end else if (expire != '0) begin
      done    <= 1'b1;
      done_ch <= bit_index(lowest_bit(expire));
      left_q  <= expire & ~lowest_bit(expire);
    end else if (left_q != '0) begin
      done    <= 1'b1;
      done_ch <= bit_index(lowest_bit(left_q));
      left_q  <= left_q & ~lowest_bit(left_q);
    end else begin
      done    <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_vch_sched_chk.sv
module adc_vch_sched_chk (
  input logic       clk,
  input logic       rst,
  input logic       adc_tick,
  input logic       start_valid,
  input logic       done,
  input logic [1:0] done_ch
);
  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    adc_tick |=> !adc_tick);

  // R3
  start_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> $past(adc_tick));

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_valid |=> !start_valid);

  // R5
  done_order_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> (done_ch > $past(done_ch)));

  // R5
  done_pair_max_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |=> !done);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!adc_tick && !start_valid && !done));
endmodule

bind adc_vch_sched adc_vch_sched_chk u_chk (
  .clk(clk), .rst(rst), .adc_tick(adc_tick), .start_valid(start_valid),
  .done(done), .done_ch(done_ch)
);

// File: tb/sim_adc_vch_sched.sv
module sim_adc_vch_sched;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst = 1'b1;
  logic [2:0] cfg_div = 3'd0;
  logic       cfg_res8 = 1'b0;
  logic [3:0] cfg_gain = 4'd0;
  logic       cfg_free = 1'b0;
  logic [1:0] cfg_sweep = 2'd0;
  logic [2:0] cfg_win = 3'd0;
  logic [2:0] cfg_evmode = 3'd0;
  logic [3:0] sw_start = 4'd0;
  logic [7:0] evt_in = 8'd0;
  logic       adc_tick, start_valid, done;
  logic [1:0] start_ch, done_ch;

  adc_vch_sched u0 (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_res8(cfg_res8),
    .cfg_gain(cfg_gain), .cfg_free(cfg_free), .cfg_sweep(cfg_sweep),
    .cfg_win(cfg_win), .cfg_evmode(cfg_evmode), .sw_start(sw_start),
    .evt_in(evt_in), .adc_tick(adc_tick), .start_valid(start_valid),
    .start_ch(start_ch), .done(done), .done_ch(done_ch)
  );

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R11";

  // behavioural reference
  int  m_cnt = 0;
  bit  m_tick = 0, m_start = 0, m_done = 0;
  int  m_sch = 0, m_dch = 0;
  bit [3:0] m_pend = 0, m_left = 0;
  int  fl_ch[$];
  int  fl_rem[$];

  function automatic int wbase(input int c);
    return (c <= 4) ? c : (c == 5) ? 4 : (c == 6) ? 6 : 7;
  endfunction
  function automatic int wwidth(input int c);
    return (c <= 4) ? 4 : (c == 5) ? 3 : (c == 6) ? 2 : 1;
  endfunction
  function automatic int low_of(input bit [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_tick = 0; m_start = 0; m_done = 0; m_pend = 0; m_left = 0;
      fl_ch.delete(); fl_rem.delete();
    end else begin
      int b, w, mode, div, p;
      bit sync, sweephit, tnow;
      bit [3:0] smask, req, emask, eff;
      b = wbase(int'(cfg_win)); w = wwidth(int'(cfg_win));
      mode = int'(cfg_evmode); div = 4 << cfg_div;
      smask = 0; req = 0;
      for (int k = 0; k < 4; k++) begin
        if (k <= int'(cfg_sweep)) smask[k] = 1;
        if (mode >= 1 && mode <= 4 && k < mode && k < w && evt_in[b+k]) req[k] = 1;
      end
      sync = (mode == 6) && evt_in[b];
      sweephit = (mode == 5) && evt_in[b];
      tnow = m_tick && !sync;
      if (sync) begin m_cnt = 0; m_tick = 0; end
      else if (m_cnt >= div - 1) begin m_cnt = 0; m_tick = 1; end
      else begin m_cnt++; m_tick = 0; end
      emask = 0;
      if (tnow) begin
        for (int i = fl_rem.size() - 1; i >= 0; i--) begin
          fl_rem[i]--;
          if (fl_rem[i] == 0) begin
            emask[fl_ch[i]] = 1; fl_rem.delete(i); fl_ch.delete(i);
          end
        end
      end
      if (sync) begin
        fl_ch.delete(); fl_rem.delete(); m_done = 0; m_left = 0;
      end else if (emask != 0) begin
        m_done = 1; m_dch = low_of(emask); m_left = emask; m_left[m_dch] = 0;
      end else if (m_left != 0) begin
        m_done = 1; m_dch = low_of(m_left); m_left[m_dch] = 0;
      end else m_done = 0;
      m_start = 0;
      if (tnow) begin
        eff = m_pend;
        if (cfg_free && m_pend == 0) eff = smask;
        if (eff != 0) begin
          p = low_of(eff);
          m_start = 1; m_sch = p; eff[p] = 0;
          fl_ch.push_back(p);
          fl_rem.push_back((cfg_res8 ? 5 : 7) + int'(cfg_gain[p]));
        end
        m_pend = eff;
      end
      if (sync) m_pend = smask | sw_start;
      else m_pend = m_pend | sw_start | req | (sweephit ? smask : 4'd0);
    end
  end

  // observation
  int cnt_start[4], cnt_done[4], t_start[4], t_done[4];
  int seq[$];
  int last_tick = 0, tick_gap = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      checks++;
      if (adc_tick !== m_tick || start_valid !== m_start || done !== m_done ||
          (m_start && int'(start_ch) != m_sch) || (m_done && int'(done_ch) != m_dch)) begin
        errors++;
        $display("FAIL %s cyc %0d: tick/start/ch/done/ch = %b %b %0d %b %0d expected %b %b %0d %b %0d",
          tag, cyc, adc_tick, start_valid, start_ch, done, done_ch,
          m_tick, m_start, m_sch, m_done, m_dch);
      end
      if (adc_tick) begin tick_gap = cyc - last_tick; last_tick = cyc; end
      if (start_valid) begin
        cnt_start[start_ch]++; t_start[start_ch] = cyc; seq.push_back(int'(start_ch));
      end
      if (done) begin cnt_done[done_ch]++; t_done[done_ch] = cyc; end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 4; i++) begin cnt_start[i] = 0; cnt_done[i] = 0; end
    seq.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_sw(input logic [3:0] m);
    @(negedge clk); sw_start = m;
    @(negedge clk); sw_start = 4'd0;
  endtask

  task automatic strobe_evt(input logic [7:0] m);
    @(negedge clk); evt_in = m;
    @(negedge clk); evt_in = 8'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    tag = "R11";
    chk("R11 tick in reset", int'(adc_tick), 0);
    chk("R11 start in reset", int'(start_valid), 0);
    chk("R11 done in reset", int'(done), 0);
    rst = 1'b0;
    idle(1);
    chk("R11 outputs after reset", int'(adc_tick | start_valid | done), 0);

    tag = "R1"; idle(20);
    chk("R1 gap div4", tick_gap, 4);
    cfg_div = 3'd2; idle(60);
    chk("R1 gap div16", tick_gap, 16);
    cfg_div = 3'd0; idle(20);

    tag = "R4"; clr();
    strobe_sw(4'b0100); idle(60);
    chk("R4 ch2 12-bit latency clocks", t_done[2] - t_start[2], 28);
    chk("R4 ch2 done count", cnt_done[2], 1);
    cfg_res8 = 1'b1; cfg_gain = 4'b1000; clr();
    strobe_sw(4'b1000); idle(60);
    chk("R4 ch3 8-bit gain latency clocks", t_done[3] - t_start[3], 24);
    cfg_res8 = 1'b0; cfg_gain = 4'd0;

    tag = "R3"; clr();
    strobe_sw(4'b1111); idle(60);
    chk("R3 start count", seq.size(), 4);
    for (int i = 0; i < 4; i++) chk("R3 ascending order", (seq.size() > i) ? seq[i] : -1, i);

    tag = "R2"; clr();
    @(negedge clk); while (!adc_tick) @(negedge clk);
    strobe_sw(4'b0010); strobe_sw(4'b0010); idle(60);
    chk("R2 merged request starts", cnt_start[1], 1);
    chk("R2 merged request dones", cnt_done[1], 1);

    tag = "R5"; clr(); cfg_gain = 4'b0001;
    strobe_sw(4'b0011); idle(60);
    chk("R5 ch0 latency with gain", t_done[0] - t_start[0], 32);
    chk("R5 ch1 reported next clock", t_done[1] - t_done[0], 1);
    cfg_gain = 4'd0;

    tag = "R6"; clr(); cfg_win = 3'd5; cfg_evmode = 3'd4;
    strobe_evt(8'h80); idle(40);
    chk("R6 line 7 outside window 4..6", cnt_start[0]+cnt_start[1]+cnt_start[2]+cnt_start[3], 0);
    tag = "R7"; clr();
    strobe_evt(8'h20); idle(40);
    chk("R7 line 5 triggers ch1", cnt_start[1], 1);
    chk("R7 line 5 only ch1", cnt_start[0]+cnt_start[2]+cnt_start[3], 0);
    clr(); cfg_win = 3'd1; cfg_evmode = 3'd2;
    strobe_evt(8'h0E); idle(40);
    chk("R7 mode 2 triggers ch0", cnt_start[0], 1);
    chk("R7 mode 2 ignores ch2", cnt_start[2], 0);

    tag = "R8"; clr(); cfg_win = 3'd6; cfg_evmode = 3'd5; cfg_sweep = 2'd2;
    strobe_evt(8'h40); idle(60);
    chk("R8 sweep ch0", cnt_start[0], 1);
    chk("R8 sweep ch2", cnt_start[2], 1);
    chk("R8 sweep excludes ch3", cnt_start[3], 0);

    tag = "R9"; clr(); cfg_win = 3'd0; cfg_evmode = 3'd6; cfg_sweep = 2'd0;
    strobe_sw(4'b1111); idle(14);
    strobe_evt(8'h01); idle(80);
    chk("R9 aborted ch3 gives no done", cnt_done[3], 0);
    chk("R9 ch0 redone once", cnt_done[0], 1);
    chk("R9 divider realigned", tick_gap, 4);
    cfg_evmode = 3'd0;

    tag = "R10"; clr(); cfg_sweep = 2'd1; cfg_free = 1'b1;
    idle(80);
    cfg_free = 1'b0; idle(60);
    chk("R10 ch0 converted repeatedly", (cnt_start[0] >= 8) ? 1 : 0, 1);
    chk("R10 ch1 alternates", (cnt_start[1] >= cnt_start[0] - 1) ? 1 : 0, 1);
    chk("R10 ch2 outside set", cnt_start[2], 0);
    chk("R10 every start completes", cnt_done[0] + cnt_done[1], cnt_start[0] + cnt_start[1]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule